// File: doc/BRIEF.md
# Periodic Tick Timer with Free-Running Timestamp

This block pairs two counters behind a small register interface. A wide timestamp counter advances on every clock from reset and wraps without end; software can only read it. Beside it sits a periodic down-counter. Software programs its reload value, copies that value into the counter with a load command, and starts it with a run command. Each time the running count reaches one, the counter reloads and raises a sticky interrupt flag. At a 100 MHz clock, a reload value of 1,000,000 gives a 100 Hz tick.

Software can read the live down-count at any time. The time spent so far in the current period is (reload value − live count) clock periods, which is 10 ns each at 100 MHz. The interrupt has an enable bit and a status register that shows both the raw flag and the enabled flag. Writing a one to a clear register drops the flag. The enabled flag also leaves the block as a registered interrupt line.

Register access uses plain strobes. A write takes effect at the clock edge where `wr_en` is high. A read returns its data on `rd_data` after the edge where `rd_en` is high. Word addresses: 0 reload value (read/write); 1 control (write bits[1:0]: 00 halt, 01 load, 10 run, 11 no effect; read bit0 = running); 2 live count (read); 3 timestamp (read); 4 interrupt enable (bit0, read/write); 5 interrupt status (read: bit0 enabled flag, bit1 raw flag); 6 interrupt clear (write bit0 = 1); 7 reads as zero.

Top module: `tick_timer_unit`

## Requirements
- R1: The timestamp (address 3) is 0 after reset and grows by exactly one per clock. Two reads whose read edges are n clocks apart differ by n. A write to address 3 changes nothing.
- R2: After reset, the live count, reload value, control readback, enable and status all read 0, and `irq_o` is 0.
- R3: A load command (control write 01) copies the reload value into the live count at its write edge. While halted, the count then stays at that value.
- R4: While running, the live count drops by one at every clock edge. This includes the edge of the write that halts it.
- R5: A running count of 1 (or 0) is replaced by the reload value at the next edge, and the raw flag is set at that same edge. With reload value D, flags occur every D clocks.
- R6: The halt command (control write 00) stops counting and keeps the live count. Control bit0 then reads 0.
- R7: A load command while running reloads the count at its own edge. That edge has no decrement and no expiry.
- R8: A new reload value written while running takes effect only at the next reload. The periods that follow all have the new length.
- R9: `irq_o` equals (raw flag AND enable bit0) one clock later. Status bit0 shows raw AND enable, and status bit1 shows raw.
- R10: Writing 1 to bit0 of address 6 clears the raw flag. Writing 0 there has no effect.
- R11: If an expiry and a clear fall on the same edge, the raw flag stays set.
- R12: Control value 11 changes nothing, and a read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (nominally 100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | DATA_W (32) | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | DATA_W (32) | Read data, valid after the read edge |
| irq_o | output | 1 | Registered enabled timer interrupt |

## Verification
The period logic is swept over reload values 4 to 12. Each sweep measures the clocks between rising edges of `irq_o` while the flag is cleared after every tick, so an off-by-one in the reload compare shows up as a wrong interval. Fixed-length run windows between halt commands give exact live-count values. These separate a decrement at the halting edge, a load that also decrements, and a halt that clears the count. A reload value of 2 makes every clear collide with an expiry and so exposes which of the two has priority. A reload rewrite during a running period, timestamp reads a known number of edges apart, and mask and clear writes with both bit values cover the rest.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_RELOAD = 3'd0,
    RA_CTRL   = 3'd1,
    RA_LIVE   = 3'd2,
    RA_STAMP  = 3'd3,
    RA_IRQEN  = 3'd4,
    RA_IRQST  = 3'd5,
    RA_IRQCLR = 3'd6,
    RA_SPARE  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_HALT = 2'b00,
    OP_LOAD = 2'b01,
    OP_RUN  = 2'b10,
    OP_NONE = 2'b11
  } timer_op_e;

endpackage

// File: rtl/tick_stamp_counter.sv
module tick_stamp_counter #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STAMP_W-1:0] stamp_o
);

  logic [STAMP_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) stamp_q <= '0;
    else     stamp_q <= stamp_q + STAMP_W'(1);
  end

  assign stamp_o = stamp_q;

endmodule

// File: rtl/tick_period_counter.sv
module tick_period_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] count_q;
  logic             running_q;
  logic             at_end;

  // a count of 1 ends the period; 0 (never loaded) is treated the same
  assign at_end   = (count_q <= CNT_W'(1));
  assign expire_o = running_q && !load_i && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
    end else if (halt_i) begin
      running_q <= 1'b0;
    end else if (run_i) begin
      running_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= reload_i;
    end else if (running_q) begin
      if (at_end) count_q <= reload_i;
      else        count_q <= count_q - CNT_W'(1);
    end
  end

  assign count_o   = count_q;
  assign running_o = running_q;

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic ack_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic raw_o,
  output logic en_o,
  output logic irq_o
);

  logic raw_q;
  logic en_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
    end else if (expire_i) begin
      raw_q <= 1'b1;
    end else if (ack_i) begin
      raw_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (en_we_i) en_q <= en_d_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= raw_q & en_q;
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int STAMP_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  irq_o
);

  localparam int STAT_W = 2;

  logic [CNT_W-1:0]   reload_q;
  logic [CNT_W-1:0]   live_cnt;
  logic [STAMP_W-1:0] stamp_q;
  logic               running;
  logic               expire;
  logic               raw_flag;
  logic               irq_en;
  logic               load_pulse;
  logic               run_pulse;
  logic               halt_pulse;
  logic               ack_pulse;
  logic               en_we;
  logic               ctrl_we;
  timer_op_e          wr_op;
  logic [STAT_W-1:0]  status;
  logic [DATA_W-1:0]  rd_next;

  assign wr_op      = timer_op_e'(wr_data[1:0]);
  assign ctrl_we    = wr_en && (wr_addr == RA_CTRL);
  assign load_pulse = ctrl_we && (wr_op == OP_LOAD);
  assign run_pulse  = ctrl_we && (wr_op == OP_RUN);
  assign halt_pulse = ctrl_we && (wr_op == OP_HALT);
  assign ack_pulse  = wr_en && (wr_addr == RA_IRQCLR) && wr_data[0];
  assign en_we      = wr_en && (wr_addr == RA_IRQEN);

  always_ff @(posedge clk) begin
    if (rst)                                 reload_q <= '0;
    else if (wr_en && wr_addr == RA_RELOAD)  reload_q <= wr_data[CNT_W-1:0];
  end

  tick_stamp_counter #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst     (rst),
    .stamp_o (stamp_q)
  );

  tick_period_counter #(.CNT_W(CNT_W)) u_period (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_pulse),
    .run_i     (run_pulse),
    .halt_i    (halt_pulse),
    .reload_i  (reload_q),
    .count_o   (live_cnt),
    .running_o (running),
    .expire_o  (expire)
  );

  tick_irq_ctrl u_irq (
    .clk      (clk),
    .rst      (rst),
    .expire_i (expire),
    .ack_i    (ack_pulse),
    .en_we_i  (en_we),
    .en_d_i   (wr_data[0]),
    .raw_o    (raw_flag),
    .en_o     (irq_en),
    .irq_o    (irq_o)
  );

  assign status = {raw_flag, raw_flag & irq_en};

  always_comb begin
    rd_next = '0;
    unique case (reg_addr_e'(rd_addr))
      RA_RELOAD: rd_next = DATA_W'(reload_q);
      RA_CTRL:   rd_next = DATA_W'(running);
      RA_LIVE:   rd_next = DATA_W'(live_cnt);
      RA_STAMP:  rd_next = DATA_W'(stamp_q);
      RA_IRQEN:  rd_next = DATA_W'(irq_en);
      RA_IRQST:  rd_next = DATA_W'(status);
      RA_IRQCLR: rd_next = '0;
      RA_SPARE:  rd_next = '0;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

endmodule

// File: rtl/tick_timer_unit_chk.sv
module tick_timer_unit_chk #(
  parameter int CNT_W   = 32,
  parameter int STAMP_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [STAMP_W-1:0] stamp_q,
  input logic [CNT_W-1:0]   live_cnt,
  input logic [CNT_W-1:0]   reload_q,
  input logic               running,
  input logic               load_pulse,
  input logic               ack_pulse,
  input logic               expire,
  input logic               raw_flag,
  input logic               irq_en,
  input logic               irq_o
);

  // R1
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stamp_q == $past(stamp_q) + STAMP_W'(1));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !load_pulse) |=> live_cnt == $past(live_cnt));

  // R5
  reload_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !load_pulse && live_cnt == CNT_W'(1))
      |=> (live_cnt == $past(reload_q)) && raw_flag);

  // R7
  load_now_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> live_cnt == $past(reload_q));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == ($past(raw_flag) && $past(irq_en)));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !expire) |=> !raw_flag);

  // R11
  ack_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && expire) |=> raw_flag);

endmodule

bind tick_timer_unit tick_timer_unit_chk #(.CNT_W(CNT_W), .STAMP_W(STAMP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stamp_q    (stamp_q),
  .live_cnt   (live_cnt),
  .reload_q   (reload_q),
  .running    (running),
  .load_pulse (load_pulse),
  .ack_pulse  (ack_pulse),
  .expire     (expire),
  .raw_flag   (raw_flag),
  .irq_en     (irq_en),
  .irq_o      (irq_o)
);

// File: tb/tick_timer_unit_bench.sv
module tick_timer_unit_bench;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tick_timer_unit u_tick_timer_unit (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a negedge; the strobe is seen by the next posedge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output longint v);
    rd_en = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = longint'(rd_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for n rising edges of irq_o, clearing the flag after each, check spacing
  task automatic mon(input int n, input int exp, input string tag);
    int t[4];
    int got = 0;
    int tm = 0;
    bit prev = irq_o;
    while (got < n && tm < 400) begin
      wr_en = 1'b0;
      if (irq_o && !prev) begin
        t[got] = tm;
        got++;
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 1;
      end
      prev = irq_o;
      @(negedge clk);
      tm++;
    end
    wr_en = 1'b0;
    chk(got == n, tag, got, n);
    if (exp > 0)
      for (int i = 1; i < n; i++) chk(t[i] - t[i-1] == exp, tag, t[i] - t[i-1], exp);
  endtask

  initial begin
    longint a, b, c, v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    rd(2, v); chk(v == 0, "R2 live", v, 0);
    rd(0, v); chk(v == 0, "R2 reload", v, 0);
    rd(1, v); chk(v == 0, "R2 ctrl", v, 0);
    rd(4, v); chk(v == 0, "R2 enable", v, 0);
    rd(5, v); chk(v == 0, "R2 status", v, 0);
    chk(irq_o == 1'b0, "R2 irq", irq_o, 0);

    // R1 timestamp spacing and read-only
    rd(3, a); rd(3, b);
    chk(b - a == 1, "R1 step", b - a, 1);
    idle(5); rd(3, c);
    chk(c - b == 6, "R1 gap", c - b, 6);
    wr(3, 0); rd(3, v);
    chk(v - c == 2, "R1 write ignored", v - c, 2);

    // R3 load while halted
    wr(0, 100); wr(1, 1); idle(3);
    rd(2, v); chk(v == 100, "R3 load", v, 100);

    // R4 run 10 edges then halt; R6 hold
    wr(1, 2); idle(9); wr(1, 0);
    rd(2, v); chk(v == 90, "R4 count", v, 90);
    chk((100 - v) * 10 == 100, "R4 elapsed ns", (100 - v) * 10, 100);
    idle(7); rd(2, v); chk(v == 90, "R6 hold", v, 90);
    rd(1, v); chk(v == 0, "R6 ctrl", v, 0);

    // R7 load while running
    wr(1, 2); idle(20); wr(1, 1); wr(1, 0);
    rd(2, v); chk(v == 99, "R7 reload now", v, 99);

    // R12 no-op command and spare address
    wr(1, 3); rd(1, v); chk(v == 0, "R12 ctrl", v, 0);
    rd(2, v); chk(v == 99, "R12 live", v, 99);
    rd(7, v); chk(v == 0, "R12 spare", v, 0);

    // R9 masked flag
    wr(0, 3); wr(1, 1); wr(1, 2); idle(10); wr(1, 0);
    rd(5, v); chk(v == 2, "R9 raw only", v, 2);
    chk(irq_o == 1'b0, "R9 irq masked", irq_o, 0);
    wr(4, 1); idle(1);
    chk(irq_o == 1'b1, "R9 irq enabled", irq_o, 1);
    rd(5, v); chk(v == 3, "R9 status", v, 3);

    // R10 clear
    wr(6, 0); rd(5, v); chk(v == 3, "R10 zero write", v, 3);
    wr(6, 1); rd(5, v); chk(v == 0, "R10 cleared", v, 0);
    chk(irq_o == 1'b0, "R10 irq", irq_o, 0);

    // R5 period sweep
    for (int d = 4; d <= 12; d++) begin
      wr(0, d); wr(1, 1); wr(6, 1); wr(1, 2);
      mon(4, d, "R5 period");
      wr(1, 0); wr(6, 1);
    end

    // R8 reload rewrite while running
    wr(0, 8); wr(1, 1); wr(6, 1); wr(1, 2);
    mon(1, 0, "R8 first");
    wr(0, 5);
    mon(3, 5, "R8 new period");
    wr(1, 0); wr(6, 1);

    // R11 clear colliding with expiry
    wr(0, 2); wr(1, 1); wr(6, 1); wr(1, 2);
    mon(1, 0, "R11 first");
    for (int i = 0; i < 6; i++) begin
      chk(irq_o == 1'b1, "R11 flag kept", irq_o, 1);
      @(negedge clk);
    end
    wr(1, 0);

    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, "watchdog", n, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule